// File: doc/BRIEF.md
# Pipelined Word and Byte Memory Port

This block is the memory side of a microcoded datapath. It holds a 32-bit address register and a 32-bit data register for word traffic. It also holds a program counter and an 8-bit buffer register for instruction byte fetches. The microinstruction loads these registers from the result bus and issues read, write and fetch commands. The block turns each command into a one-cycle strobe toward a plain synchronous memory. Read data returns in the cycle of its strobe.

Word accesses are word-addressed. The byte address presented to memory is the address register scaled by four. A read or fetch issued in cycle k drives its strobe in cycle k+1, and its result can be used from cycle k+2. The target register keeps its old contents until then. A new command may be issued in every cycle, so reads in k and k+1 complete in k+2 and k+3. The buffer register is offered to the datapath in two forms: sign-extended and zero-extended.

Top module: `mp_mem_port`

## Requirements
- R1: While `rst_n` is low, the four registers (`addr_q`, `data_q`, `pc_q`, `buf_q`) are zero and `mem_rd`, `mem_wr` and `mem_fetch` are low.
- R2: When `ld_addr` or `ld_pc` is high in a cycle, `c_bus` appears on `addr_q` or `pc_q` from the next cycle. Otherwise the register holds its value.
- R3: `cmd_rd` in cycle k drives `mem_rd` high for cycle k+1 only. In that cycle `mem_addr` equals `addr_q` shifted left by two, with bits 1:0 zero.
- R4: A read issued in cycle k writes `mem_rdata` of cycle k+1 into `data_q`, visible from cycle k+2. Without a landing read, `data_q` changes only through `ld_data`, one cycle after it is asserted.
- R5: Reads issued in consecutive cycles k and k+1 land in `data_q` in cycles k+2 and k+3, each with the data of its own address.
- R6: `cmd_wr` in cycle k drives `mem_wr` high for cycle k+1 only. In that cycle `mem_addr` is the scaled address and `mem_wdata` equals `data_q`. A write never changes `data_q`.
- R7: `cmd_fetch` in cycle k drives `mem_fetch` high in cycle k+1 with `mem_baddr` equal to `pc_q`, unscaled. `mem_fdata` of that cycle appears in `buf_q` from cycle k+2.
- R8: When a landing read and `ld_data` fall in the same cycle, the memory data is taken and the `c_bus` value is discarded.
- R9: When `cmd_rd` and `cmd_wr` are high in the same cycle, only the read is issued. No `mem_wr` strobe follows, and `mem_rd` and `mem_wr` are never high together.
- R10: A read followed by a write in the next cycle strobes memory in issue order. The write carries the data the read just returned.
- R11: `buf_sx` is `buf_q` sign-extended from bit 7 to 32 bits. `buf_zx` is `buf_q` with zeros in bits 31:8.
- R12: A fetch and a word read or write issued in the same cycle proceed independently, each with unchanged timing.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous reset, active low |
| c_bus | input | 32 | Result bus value for register loads |
| ld_addr | input | 1 | Load address register from `c_bus` |
| ld_data | input | 1 | Load data register from `c_bus` |
| ld_pc | input | 1 | Load program counter from `c_bus` |
| cmd_rd | input | 1 | Issue word read |
| cmd_wr | input | 1 | Issue word write |
| cmd_fetch | input | 1 | Issue byte fetch |
| mem_rdata | input | 32 | Word read data, valid in the `mem_rd` cycle |
| mem_fdata | input | 8 | Fetch byte, valid in the `mem_fetch` cycle |
| addr_q | output | 32 | Address register |
| data_q | output | 32 | Data register |
| pc_q | output | 32 | Program counter |
| buf_q | output | 8 | Byte buffer register |
| buf_sx | output | 32 | Buffer, sign-extended |
| buf_zx | output | 32 | Buffer, zero-extended |
| mem_addr | output | 32 | Word access byte address |
| mem_wdata | output | 32 | Write data |
| mem_rd | output | 1 | Read strobe |
| mem_wr | output | 1 | Write strobe |
| mem_baddr | output | 32 | Fetch byte address |
| mem_fetch | output | 1 | Fetch strobe |

## Verification
Two things compete for the data register in one cycle: a read result that is landing, and a load from the result bus. The bench provokes this by issuing a read and asserting `ld_data` in the very next cycle with a distinct pattern. The register must show the memory word, not the bus value. A read and a write issued in the same cycle are provoked the same way. They are judged by the absence of any write strobe. Both cases also occur in a long randomized stretch. There, a behavioural queue-based model predicts every register and strobe on each clock.

// File: rtl/mp_pkg.sv
package mp_pkg;
   typedef struct packed {
      logic rd;
      logic wr;
      logic fetch;
   } mp_cmd_t;

   localparam int unsigned MP_WORD_BYTES_LOG2 = 2;
endpackage

// File: rtl/mp_byte_extend.sv
module mp_byte_extend #(
   parameter int unsigned IN_W   = 8,
   parameter int unsigned OUT_W  = 32,
   parameter bit          SIGNED = 1'b1
) (
   input  logic [IN_W-1:0]  din,
   output logic [OUT_W-1:0] dout
);
   localparam int unsigned PAD_W = OUT_W - IN_W;

   generate
      if (SIGNED) begin : g_sx
         assign dout = {{PAD_W{din[IN_W-1]}}, din};
      end else begin : g_zx
         assign dout = {{PAD_W{1'b0}}, din};
      end
   endgenerate
endmodule

// File: rtl/mp_word_port.sv
module mp_word_port #(
   parameter int unsigned DATA_W     = 32,
   parameter int unsigned ADDR_SHIFT = 2
) (
   input  logic              clk,
   input  logic              rst_n,
   input  logic [DATA_W-1:0] c_bus,
   input  logic              ld_addr,
   input  logic              ld_data,
   input  logic              cmd_rd,
   input  logic              cmd_wr,
   input  logic [DATA_W-1:0] mem_rdata,
   output logic [DATA_W-1:0] addr_q,
   output logic [DATA_W-1:0] data_q,
   output logic [DATA_W-1:0] mem_addr,
   output logic [DATA_W-1:0] mem_wdata,
   output logic              mem_rd,
   output logic              mem_wr
);
   logic rd_pend;
   logic wr_pend;

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         addr_q  <= '0;
         data_q  <= '0;
         rd_pend <= 1'b0;
         wr_pend <= 1'b0;
      end else begin
         rd_pend <= cmd_rd;
         wr_pend <= cmd_wr & ~cmd_rd;
         if (ld_addr) addr_q <= c_bus;
         if (rd_pend)      data_q <= mem_rdata;
         else if (ld_data) data_q <= c_bus;
      end
   end

   generate
      if (ADDR_SHIFT == 0) begin : g_noscale
         assign mem_addr = addr_q;
      end else begin : g_scale
         assign mem_addr = {addr_q[DATA_W-1-ADDR_SHIFT:0], {ADDR_SHIFT{1'b0}}};
      end
   endgenerate

   assign mem_wdata = data_q;
   assign mem_rd    = rd_pend;
   assign mem_wr    = wr_pend;
endmodule

// File: rtl/mp_byte_port.sv
module mp_byte_port #(
   parameter int unsigned PC_W   = 32,
   parameter int unsigned BYTE_W = 8
) (
   input  logic              clk,
   input  logic              rst_n,
   input  logic [PC_W-1:0]   c_bus,
   input  logic              ld_pc,
   input  logic              cmd_fetch,
   input  logic [BYTE_W-1:0] mem_fdata,
   output logic [PC_W-1:0]   pc_q,
   output logic [BYTE_W-1:0] buf_q,
   output logic [PC_W-1:0]   mem_baddr,
   output logic              mem_fetch
);
   logic fetch_pend;

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         pc_q       <= '0;
         buf_q      <= '0;
         fetch_pend <= 1'b0;
      end else begin
         fetch_pend <= cmd_fetch;
         if (ld_pc)      pc_q  <= c_bus;
         if (fetch_pend) buf_q <= mem_fdata;
      end
   end

   assign mem_baddr = pc_q;
   assign mem_fetch = fetch_pend;
endmodule

// File: rtl/mp_mem_port.sv
module mp_mem_port #(
   parameter int unsigned DATA_W     = 32,
   parameter int unsigned BYTE_W     = 8,
   parameter int unsigned ADDR_SHIFT = mp_pkg::MP_WORD_BYTES_LOG2
) (
   input  logic              clk,
   input  logic              rst_n,
   input  logic [DATA_W-1:0] c_bus,
   input  logic              ld_addr,
   input  logic              ld_data,
   input  logic              ld_pc,
   input  logic              cmd_rd,
   input  logic              cmd_wr,
   input  logic              cmd_fetch,
   input  logic [DATA_W-1:0] mem_rdata,
   input  logic [BYTE_W-1:0] mem_fdata,
   output logic [DATA_W-1:0] addr_q,
   output logic [DATA_W-1:0] data_q,
   output logic [DATA_W-1:0] pc_q,
   output logic [BYTE_W-1:0] buf_q,
   output logic [DATA_W-1:0] buf_sx,
   output logic [DATA_W-1:0] buf_zx,
   output logic [DATA_W-1:0] mem_addr,
   output logic [DATA_W-1:0] mem_wdata,
   output logic              mem_rd,
   output logic              mem_wr,
   output logic [DATA_W-1:0] mem_baddr,
   output logic              mem_fetch
);
   import mp_pkg::*;

   generate
      if (BYTE_W >= DATA_W) begin : g_bad_byte_w
         $error("mp_mem_port: BYTE_W must be narrower than DATA_W");
      end
      if (ADDR_SHIFT >= DATA_W) begin : g_bad_shift
         $error("mp_mem_port: ADDR_SHIFT must be below DATA_W");
      end
   endgenerate

   mp_cmd_t cmd;
   assign cmd = '{rd: cmd_rd, wr: cmd_wr, fetch: cmd_fetch};

   mp_word_port #(.DATA_W(DATA_W), .ADDR_SHIFT(ADDR_SHIFT)) u_word (
      .clk(clk), .rst_n(rst_n), .c_bus(c_bus),
      .ld_addr(ld_addr), .ld_data(ld_data),
      .cmd_rd(cmd.rd), .cmd_wr(cmd.wr), .mem_rdata(mem_rdata),
      .addr_q(addr_q), .data_q(data_q), .mem_addr(mem_addr),
      .mem_wdata(mem_wdata), .mem_rd(mem_rd), .mem_wr(mem_wr)
   );

   mp_byte_port #(.PC_W(DATA_W), .BYTE_W(BYTE_W)) u_byte (
      .clk(clk), .rst_n(rst_n), .c_bus(c_bus), .ld_pc(ld_pc),
      .cmd_fetch(cmd.fetch), .mem_fdata(mem_fdata),
      .pc_q(pc_q), .buf_q(buf_q), .mem_baddr(mem_baddr), .mem_fetch(mem_fetch)
   );

   mp_byte_extend #(.IN_W(BYTE_W), .OUT_W(DATA_W), .SIGNED(1'b1)) u_sx (
      .din(buf_q), .dout(buf_sx)
   );

   mp_byte_extend #(.IN_W(BYTE_W), .OUT_W(DATA_W), .SIGNED(1'b0)) u_zx (
      .din(buf_q), .dout(buf_zx)
   );
endmodule

// File: rtl/mp_mem_port_chk.sv
module mp_mem_port_chk #(
   parameter int unsigned DATA_W = 32,
   parameter int unsigned BYTE_W = 8
) (
   input logic              clk,
   input logic              rst_n,
   input logic              ld_data,
   input logic              cmd_rd,
   input logic              cmd_wr,
   input logic              cmd_fetch,
   input logic [DATA_W-1:0] mem_rdata,
   input logic [BYTE_W-1:0] mem_fdata,
   input logic [DATA_W-1:0] data_q,
   input logic [BYTE_W-1:0] buf_q,
   input logic [DATA_W-1:0] buf_sx,
   input logic              mem_rd,
   input logic              mem_wr,
   input logic              mem_fetch
);
   assert_reset_idle_R1: assert property (@(posedge clk)
      !rst_n |-> (!mem_rd && !mem_wr && !mem_fetch));

   assert_rd_strobe_R3: assert property (@(posedge clk) disable iff (!rst_n)
      cmd_rd |=> mem_rd);

   assert_rd_lands_R4: assert property (@(posedge clk) disable iff (!rst_n)
      mem_rd |=> (data_q == $past(mem_rdata)));

   assert_data_hold_R4: assert property (@(posedge clk) disable iff (!rst_n)
      (!mem_rd && !ld_data) |=> $stable(data_q));

   assert_wr_strobe_R6: assert property (@(posedge clk) disable iff (!rst_n)
      (cmd_wr && !cmd_rd) |=> mem_wr);

   assert_fetch_R7: assert property (@(posedge clk) disable iff (!rst_n)
      cmd_fetch |=> (mem_fetch && !$stable(mem_fetch) || mem_fetch));

   assert_buf_lands_R7: assert property (@(posedge clk) disable iff (!rst_n)
      mem_fetch |=> (buf_q == $past(mem_fdata)));

   assert_no_dual_strobe_R9: assert property (@(posedge clk) disable iff (!rst_n)
      !(mem_rd && mem_wr));

   assert_sign_ext_R11: assert property (@(posedge clk) disable iff (!rst_n)
      buf_sx[DATA_W-1] == buf_q[BYTE_W-1]);
endmodule

bind mp_mem_port mp_mem_port_chk #(.DATA_W(DATA_W), .BYTE_W(BYTE_W)) u_chk (
   .clk(clk), .rst_n(rst_n), .ld_data(ld_data),
   .cmd_rd(cmd_rd), .cmd_wr(cmd_wr), .cmd_fetch(cmd_fetch),
   .mem_rdata(mem_rdata), .mem_fdata(mem_fdata),
   .data_q(data_q), .buf_q(buf_q), .buf_sx(buf_sx),
   .mem_rd(mem_rd), .mem_wr(mem_wr), .mem_fetch(mem_fetch)
);

// File: tb/mp_mem_port_test.sv
`timescale 1ns/1ps
module mp_mem_port_test;
   logic        clk = 1'b0;
   logic        rst_n;
   logic [31:0] c_bus = '0;
   logic        ld_addr = 0, ld_data = 0, ld_pc = 0;
   logic        cmd_rd = 0, cmd_wr = 0, cmd_fetch = 0;
   logic [31:0] mem_rdata;
   logic [7:0]  mem_fdata;
   logic [31:0] addr_q, data_q, pc_q, buf_sx, buf_zx, mem_addr, mem_wdata, mem_baddr;
   logic [7:0]  buf_q;
   logic        mem_rd, mem_wr, mem_fetch;

   int checks = 0;
   int errors = 0;
   bit checking = 0;
   bit done = 0;
   string phase = "init";

   always #2.5 clk = ~clk;

   mp_mem_port uut (
      .clk(clk), .rst_n(rst_n), .c_bus(c_bus),
      .ld_addr(ld_addr), .ld_data(ld_data), .ld_pc(ld_pc),
      .cmd_rd(cmd_rd), .cmd_wr(cmd_wr), .cmd_fetch(cmd_fetch),
      .mem_rdata(mem_rdata), .mem_fdata(mem_fdata),
      .addr_q(addr_q), .data_q(data_q), .pc_q(pc_q), .buf_q(buf_q),
      .buf_sx(buf_sx), .buf_zx(buf_zx), .mem_addr(mem_addr),
      .mem_wdata(mem_wdata), .mem_rd(mem_rd), .mem_wr(mem_wr),
      .mem_baddr(mem_baddr), .mem_fetch(mem_fetch)
   );

   // memory model: 64 words, combinational read, write at the edge
   logic [31:0] mem [0:63];
   logic [31:0] ref_mem [0:63];
   initial begin
      for (int i = 0; i < 64; i++) begin
         mem[i]     = 32'h1000_0000 + i * 32'h0101_0011;
         ref_mem[i] = 32'h1000_0000 + i * 32'h0101_0011;
      end
   end
   assign mem_rdata = mem[mem_addr[7:2]];
   always @(posedge clk) if (mem_wr) mem[mem_addr[7:2]] <= mem_wdata;

   function automatic logic [7:0] fbyte(input logic [31:0] a);
      return 8'(a[7:0] * 8'd13 + 8'h5A);
   endfunction
   assign mem_fdata = fbyte(mem_baddr);

   // behavioural reference: pending commands kept in queues
   logic [31:0] e_addr = '0, e_data = '0, e_pc = '0;
   logic [7:0]  e_buf = '0;
   bit          rd_q[$], wr_q[$], f_q[$];
   bit          e_rd = 0, e_wr = 0, e_f = 0;

   always @(posedge clk) begin
      if (!rst_n) begin
         e_addr = '0; e_data = '0; e_pc = '0; e_buf = '0;
         e_rd = 0; e_wr = 0; e_f = 0;
         rd_q.delete(); wr_q.delete(); f_q.delete();
      end else begin
         logic [31:0] nd;
         logic [7:0]  nb;
         nd = e_rd ? ref_mem[e_addr[5:0]] : (ld_data ? c_bus : e_data);
         if (e_wr) ref_mem[e_addr[5:0]] = e_data;
         nb = e_f ? fbyte(e_pc) : e_buf;
         rd_q.push_back(cmd_rd);
         wr_q.push_back(cmd_wr && !cmd_rd);
         f_q.push_back(cmd_fetch);
         e_rd = rd_q.pop_front();
         e_wr = wr_q.pop_front();
         e_f  = f_q.pop_front();
         if (ld_addr) e_addr = c_bus;
         if (ld_pc)   e_pc = c_bus;
         e_data = nd;
         e_buf  = nb;
      end
   end

   task automatic chk(input bit ok, input string req, input logic [31:0] act, input logic [31:0] exp);
      checks++;
      if (!ok) begin
         errors++;
         $display("FAIL %s [%s] actual=%h expected=%h at %0t", req, phase, act, exp, $time);
      end
   endtask

   always @(negedge clk) begin
      if (checking && rst_n) begin
         chk(addr_q == e_addr, "R2 addr_q", addr_q, e_addr);
         chk(pc_q == e_pc, "R2 pc_q", pc_q, e_pc);
         chk(data_q == e_data, "R4 data_q", data_q, e_data);
         chk(mem_rd == e_rd, "R3 mem_rd", 32'(mem_rd), 32'(e_rd));
         chk(mem_wr == e_wr, "R6 mem_wr", 32'(mem_wr), 32'(e_wr));
         chk(mem_fetch == e_f, "R7 mem_fetch", 32'(mem_fetch), 32'(e_f));
         chk(buf_q == e_buf, "R7 buf_q", 32'(buf_q), 32'(e_buf));
         chk(mem_baddr == e_pc, "R7 mem_baddr", mem_baddr, e_pc);
         if (e_rd || e_wr)
            chk(mem_addr == {e_addr[29:0], 2'b00}, "R3 mem_addr", mem_addr, {e_addr[29:0], 2'b00});
         if (e_wr)
            chk(mem_wdata == e_data, "R6 mem_wdata", mem_wdata, e_data);
         chk(buf_sx == {{24{e_buf[7]}}, e_buf}, "R11 buf_sx", buf_sx, {{24{e_buf[7]}}, e_buf});
         chk(buf_zx == {24'h0, e_buf}, "R11 buf_zx", buf_zx, {24'h0, e_buf});
      end
   end

   task automatic step(input bit la, input bit ld, input bit lp,
                       input bit r, input bit w, input bit f, input logic [31:0] c);
      ld_addr = la; ld_data = ld; ld_pc = lp;
      cmd_rd = r; cmd_wr = w; cmd_fetch = f; c_bus = c;
      @(negedge clk);
   endtask

   task automatic idle(input int n);
      for (int i = 0; i < n; i++) step(0, 0, 0, 0, 0, 0, 32'h0);
   endtask

   initial begin
      rst_n = 1'b0;
      repeat (3) @(negedge clk);
      phase = "R1";
      chk(addr_q == 0 && data_q == 0 && pc_q == 0 && buf_q == 0, "R1 regs", data_q, 32'h0);
      chk(!mem_rd && !mem_wr && !mem_fetch, "R1 strobes",
          32'({mem_rd, mem_wr, mem_fetch}), 32'h0);
      rst_n = 1'b1;
      checking = 1;
      @(negedge clk);

      phase = "R2 loads";
      step(1, 1, 1, 0, 0, 0, 32'h0000_0003);
      step(0, 1, 0, 0, 0, 0, 32'hA5A5_0001);
      phase = "R6 write";
      step(0, 0, 0, 0, 1, 0, 32'h0);
      step(1, 1, 0, 0, 0, 0, 32'h0000_0005);
      step(0, 0, 0, 0, 1, 0, 32'h0);
      idle(2);

      phase = "R3 R4 read";
      step(1, 0, 0, 0, 0, 0, 32'h0000_0003);
      step(0, 0, 0, 1, 0, 0, 32'h0);
      idle(3);

      phase = "R5 back-to-back";
      step(1, 0, 0, 0, 0, 0, 32'h0000_0003);
      step(1, 0, 0, 1, 0, 0, 32'h0000_0005);
      step(0, 0, 0, 1, 0, 0, 32'h0);
      idle(3);

      phase = "R8 land vs load";
      step(1, 0, 0, 1, 0, 0, 32'h0000_0007);
      step(0, 1, 0, 0, 0, 0, 32'hDEAD_BEEF);
      idle(2);

      phase = "R9 rd+wr";
      step(0, 1, 0, 0, 0, 0, 32'h1234_5678);
      step(0, 0, 0, 1, 1, 0, 32'h0);
      chk(mem_rd && !mem_wr, "R9 only read", 32'({mem_rd, mem_wr}), 32'h2);
      idle(2);

      phase = "R10 rd then wr";
      step(1, 1, 0, 0, 0, 0, 32'h0000_0009);
      step(0, 0, 0, 1, 0, 0, 32'h0);
      step(1, 0, 0, 0, 1, 0, 32'h0000_000A);
      idle(3);

      phase = "R7 R11 fetch";
      step(0, 0, 1, 0, 0, 0, 32'h0000_0002);
      step(0, 0, 1, 0, 0, 1, 32'h0000_0011);
      step(0, 0, 0, 0, 0, 1, 32'h0);
      idle(3);

      phase = "R12 fetch+read";
      step(1, 0, 1, 0, 0, 0, 32'h0000_0004);
      step(0, 0, 0, 1, 0, 1, 32'h0);
      step(0, 1, 0, 0, 1, 1, 32'h0BAD_F00D);
      idle(3);

      phase = "random";
      for (int i = 0; i < 400; i++)
         step(1'($urandom), 1'($urandom), 1'($urandom),
              1'($urandom), 1'($urandom), 1'($urandom),
              $urandom & 32'h8000_00FF);
      idle(3);

      done = 1;
      $display("Simulation finished: %0d checks, %0d errors", checks, errors);
      $finish;
   end

   initial begin
      repeat (200000) @(posedge clk);
      if (!done) begin
         errors++;
         $display("FAIL watchdog expired");
         $display("Simulation finished: %0d checks, %0d errors", checks, errors);
         $finish;
      end
   end
endmodule